// File: doc/BRIEF.md
# Boot Sector Write Guard

This block sits between a flash command decoder and the array sequencer and decides, one request at a time, whether a program, sector-erase or chip-erase operation may go ahead. It protects a fixed 16 KB boot sector inside a 17-bit byte address space. A parameter places that sector at the bottom or at the top of the space. Once a lock request has been seen, a one-way lock flag guards the sector. The flag is non-volatile in the real part. Here it is a register that only a preset input clears, which models a fresh device.

Each request is answered on the following clock edge with exactly one of two pulses. A grant pulse carries the operation and its address on to the array sequencer. A reject pulse means the array is not touched at all and no busy period follows. A chip erase is never rejected; instead its grant carries a flag that tells the sequencer to leave the boot sector intact. A high-voltage override input lets boot-sector writes through for as long as it is held. A second parameter builds a permanent-lock variant in which that input has no effect. While identification mode is active, the lock state can be read at offset 2 of the boot sector.

Top module: `bootsec_guard`

## Requirements
- R1: The boot sector is byte addresses 0x00000–0x03FFF when TOP_BOOT=0 and 0x1C000–0x1FFFF when TOP_BOOT=1. Addresses one below or one above these bounds are treated as ordinary sectors.
- R2: req_kind is encoded as 00 program, 01 sector erase, 10 chip erase and 11 lock. With the lock flag clear, every request is answered one cycle later by a single-cycle grant_valid pulse that repeats req_kind and req_addr, and reject stays low.
- R3: With the lock effective, a program or sector-erase request whose address lies in the boot sector gives a single-cycle reject pulse one cycle later and no grant_valid.
- R4: With the lock set, program and sector-erase requests outside the boot sector are still granted.
- R5: A chip erase is always granted. grant_keep_boot is 1 in that grant exactly when the lock is effective, and it is 0 otherwise.
- R6: A lock request is granted and sets the lock flag from the next cycle on. The flag survives rst_n and is cleared only by preset.
- R7: In the default variant, a request made while hv_override is high is handled as though the lock were clear. Protection applies again to the first request made after hv_override falls.
- R8: With PERMANENT=1, hv_override has no effect on any response.
- R9: While id_mode is high and rd_addr equals the boot-sector base plus 2 (0x00002 bottom, 0x1C002 top), id_data is the lock flag on bit 0 with all other bits 0. For every other id_mode and rd_addr combination, id_data is 0x00. The read path is combinational.
- R10: While rst_n is low, and in the cycles without a request, grant_valid, reject and grant_keep_boot are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the response logic |
| preset | input | 1 | Clears the lock flag, modelling a fresh device |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 lock |
| req_addr | input | ADDR_W | Byte address of the request |
| hv_override | input | 1 | High-voltage override level on the reset pin |
| id_mode | input | 1 | Identification mode is active |
| rd_addr | input | ADDR_W | Read address in identification mode |
| id_data | output | ID_W | Lock status read data |
| grant_valid | output | 1 | Request allowed (one-cycle pulse) |
| grant_kind | output | 2 | Operation kind of the granted request |
| grant_addr | output | ADDR_W | Address of the granted request |
| grant_keep_boot | output | 1 | Chip erase must skip the boot sector |
| reject | output | 1 | Request refused, no array access (one-cycle pulse) |

## Verification
The bench probes the first and last byte of the boot sector and the bytes just past it on both placements. A decoder that is off by one bit would then reject a write to a neighbouring parameter sector, or let one boot byte through. Chip erase under lock is checked for the keep-boot flag; a design that rejected the erase outright, or skipped the flag, would either leave every sector unerased or wipe the boot code. The override is applied to a default and a permanent instance side by side, and then released. A design that ignored the permanent variant, or latched the override, would grant a boot write it must refuse. Pulsing rst_n and then preset shows whether the flag wrongly follows the ordinary reset, and whether the identification read reports it at the right address only.

// File: rtl/bootsec_pkg.sv
package bootsec_pkg;
   typedef enum logic [1:0] {
      OP_PROG   = 2'b00,
      OP_SERASE = 2'b01,
      OP_CHIP   = 2'b10,
      OP_LOCK   = 2'b11
   } op_e;
endpackage

// File: rtl/bootsec_region.sv
module bootsec_region #(
   parameter int ADDR_W   = 17,
   parameter int BOOT_W   = 14,
   parameter bit TOP_BOOT = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int TAG_W = ADDR_W - BOOT_W;

   logic [TAG_W-1:0] tag;
   assign tag = addr[ADDR_W-1:BOOT_W];

   generate
      if (TOP_BOOT) begin : g_top
         always_comb hit = &tag;
      end else begin : g_bottom
         always_comb hit = ~|tag;
      end
   endgenerate
endmodule

// File: rtl/bootsec_lockreg.sv
module bootsec_lockreg (
   input  logic clk,
   input  logic preset,
   input  logic set_lock,
   output logic lock_q
);
   // Models a non-volatile bit: the ordinary reset does not touch it.
   always_ff @(posedge clk) begin
      if (preset)
         lock_q <= 1'b0;
      else if (set_lock)
         lock_q <= 1'b1;
   end
endmodule

// File: rtl/bootsec_decide.sv
module bootsec_decide
   import bootsec_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter bit PERMANENT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_boot,
   input  logic              lock_q,
   input  logic              hv_override,
   output logic              set_lock,
   output logic              grant_valid,
   output logic [1:0]        grant_kind,
   output logic [ADDR_W-1:0] grant_addr,
   output logic              grant_keep_boot,
   output logic              reject
);
   logic ovr_eff;
   logic protect;
   logic is_write;
   logic block;
   op_e  kind;

   generate
      if (PERMANENT) begin : g_perm
         logic unused_ovr;
         assign unused_ovr = hv_override;
         assign ovr_eff    = 1'b0;
      end else begin : g_ovr
         assign ovr_eff = hv_override;
      end
   endgenerate

   always_comb begin
      kind     = op_e'(req_kind);
      protect  = lock_q & ~ovr_eff;
      is_write = (kind == OP_PROG) || (kind == OP_SERASE);
      block    = req_valid & is_write & req_boot & protect;
      set_lock = req_valid & (kind == OP_LOCK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_valid     <= 1'b0;
         grant_kind      <= 2'b00;
         grant_addr      <= '0;
         grant_keep_boot <= 1'b0;
         reject          <= 1'b0;
      end else begin
         grant_valid     <= req_valid & ~block;
         reject          <= block;
         grant_kind      <= req_kind;
         grant_addr      <= req_addr;
         grant_keep_boot <= req_valid & (kind == OP_CHIP) & protect;
      end
   end
endmodule

// File: rtl/bootsec_guard.sv
module bootsec_guard #(
   parameter int ADDR_W    = 17,
   parameter int BOOT_W    = 14,
   parameter int ID_W      = 8,
   parameter int ID_OFFSET = 2,
   parameter bit TOP_BOOT  = 1'b0,
   parameter bit PERMANENT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              preset,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              hv_override,
   input  logic              id_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [ID_W-1:0]   id_data,
   output logic              grant_valid,
   output logic [1:0]        grant_kind,
   output logic [ADDR_W-1:0] grant_addr,
   output logic              grant_keep_boot,
   output logic              reject
);
   localparam logic [ADDR_W-1:0] BOOT_SPAN = ADDR_W'(1) << BOOT_W;
   localparam logic [ADDR_W-1:0] BOOT_BASE = TOP_BOOT ? ('0 - BOOT_SPAN) : '0;
   localparam logic [ADDR_W-1:0] ID_ADDR   = BOOT_BASE + ADDR_W'(ID_OFFSET);

   generate
      if (ADDR_W <= BOOT_W) begin : g_bad_width
         $error("bootsec_guard: ADDR_W must exceed BOOT_W");
      end
      if (ID_OFFSET < 0 || ID_OFFSET >= (1 << BOOT_W)) begin : g_bad_offset
         $error("bootsec_guard: ID_OFFSET outside the boot sector");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("bootsec_guard: ID_W must be at least 1");
      end
   endgenerate

   logic req_boot;
   logic set_lock;
   logic lock_q;

   bootsec_region #(
      .ADDR_W   (ADDR_W),
      .BOOT_W   (BOOT_W),
      .TOP_BOOT (TOP_BOOT)
   ) u_region (
      .addr (req_addr),
      .hit  (req_boot)
   );

   bootsec_lockreg u_lock (
      .clk      (clk),
      .preset   (preset),
      .set_lock (set_lock),
      .lock_q   (lock_q)
   );

   bootsec_decide #(
      .ADDR_W    (ADDR_W),
      .PERMANENT (PERMANENT)
   ) u_decide (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid       (req_valid),
      .req_kind        (req_kind),
      .req_addr        (req_addr),
      .req_boot        (req_boot),
      .lock_q          (lock_q),
      .hv_override     (hv_override),
      .set_lock        (set_lock),
      .grant_valid     (grant_valid),
      .grant_kind      (grant_kind),
      .grant_addr      (grant_addr),
      .grant_keep_boot (grant_keep_boot),
      .reject          (reject)
   );

   always_comb begin
      id_data = '0;
      if (id_mode && (rd_addr == ID_ADDR))
         id_data[0] = lock_q;
   end
endmodule

// File: rtl/bootsec_guard_chk.sv
module bootsec_guard_chk #(
   parameter int ADDR_W    = 17,
   parameter int BOOT_W    = 14,
   parameter bit TOP_BOOT  = 1'b0,
   parameter bit PERMANENT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              preset,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic [ADDR_W-1:0] req_addr,
   input logic              hv_override,
   input logic              lock_q,
   input logic              grant_valid,
   input logic [1:0]        grant_kind,
   input logic [ADDR_W-1:0] grant_addr,
   input logic              grant_keep_boot,
   input logic              reject
);
   localparam int TAG_W = ADDR_W - BOOT_W;
   localparam logic [TAG_W-1:0] TAG = TOP_BOOT ? {TAG_W{1'b1}} : {TAG_W{1'b0}};

   logic req_in_boot;
   logic grant_in_boot;
   assign req_in_boot   = (req_addr[ADDR_W-1:BOOT_W] == TAG);
   assign grant_in_boot = (grant_addr[ADDR_W-1:BOOT_W] == TAG);

   // R2
   one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (grant_valid ^ reject));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(grant_valid || reject || grant_keep_boot));

   // R3
   reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> ($past(lock_q) && $past(req_in_boot)
                  && ($past(req_kind) == 2'b00 || $past(req_kind) == 2'b01)));

   // R6
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !preset) |=> lock_q);

   // R5
   keep_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && grant_kind == 2'b10 && !grant_keep_boot)
         |-> (!$past(lock_q) || (!PERMANENT && $past(hv_override))));

   generate
      if (PERMANENT) begin : g_perm
         // R8
         perm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_valid && grant_in_boot
             && (grant_kind == 2'b00 || grant_kind == 2'b01)) |-> !$past(lock_q));
      end
   endgenerate
endmodule

bind bootsec_guard bootsec_guard_chk #(
   .ADDR_W    (ADDR_W),
   .BOOT_W    (BOOT_W),
   .TOP_BOOT  (TOP_BOOT),
   .PERMANENT (PERMANENT)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .preset          (preset),
   .req_valid       (req_valid),
   .req_kind        (req_kind),
   .req_addr        (req_addr),
   .hv_override     (hv_override),
   .lock_q          (lock_q),
   .grant_valid     (grant_valid),
   .grant_kind      (grant_kind),
   .grant_addr      (grant_addr),
   .grant_keep_boot (grant_keep_boot),
   .reject          (reject)
);

// File: tb/bootsec_guard_tb.sv
module bootsec_guard_tb;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          preset = 1'b1;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic          hv_override = 1'b0;
   logic          id_mode = 1'b0;
   logic [AW-1:0] rd_addr = '0;

   logic [7:0]    b_id, t_id;
   logic          b_gv, t_gv, b_kb, t_kb, b_rj, t_rj;
   logic [1:0]    b_gk, t_gk;
   logic [AW-1:0] b_ga, t_ga;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;
   bit  lk = 0;   // bench model of the lock flag, shared by both instances

   always #4 clk = ~clk;

   // bottom boot, override allowed
   bootsec_guard #(.TOP_BOOT(1'b0), .PERMANENT(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .preset(preset), .req_valid(req_valid),
      .req_kind(req_kind), .req_addr(req_addr), .hv_override(hv_override),
      .id_mode(id_mode), .rd_addr(rd_addr), .id_data(b_id),
      .grant_valid(b_gv), .grant_kind(b_gk), .grant_addr(b_ga),
      .grant_keep_boot(b_kb), .reject(b_rj));

   // top boot, permanent lock
   bootsec_guard #(.TOP_BOOT(1'b1), .PERMANENT(1'b1)) u_dut_perm (
      .clk(clk), .rst_n(rst_n), .preset(preset), .req_valid(req_valid),
      .req_kind(req_kind), .req_addr(req_addr), .hv_override(hv_override),
      .id_mode(id_mode), .rd_addr(rd_addr), .id_data(t_id),
      .grant_valid(t_gv), .grant_kind(t_gk), .grant_addr(t_ga),
      .grant_keep_boot(t_kb), .reject(t_rj));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // R1 address map, used for expectations
   function automatic bit in_boot(input logic [AW-1:0] a, input bit top);
      if (top) return a >= 17'h1C000;
      return a <= 17'h03FFF;
   endfunction

   task automatic judge(input string tag, input bit top, input bit perm,
                        input logic [1:0] k, input logic [AW-1:0] a, input bit ovr,
                        input logic gv, input logic [1:0] gk, input logic [AW-1:0] ga,
                        input logic kb, input logic rj);
      bit prot, blk;
      prot = lk && !(ovr && !perm);
      blk  = (k == 2'b00 || k == 2'b01) && in_boot(a, top) && prot;
      check({tag, " grant"}, gv, !blk);
      check({tag, " reject"}, rj, blk);
      check({tag, " keep"}, kb, (k == 2'b10) && prot);
      if (!blk) begin
         check({tag, " kind"}, gk, k);
         check({tag, " addr"}, ga, a);
      end
   endtask

   task automatic issue(input string tag, input logic [1:0] k, input logic [AW-1:0] a, input bit ovr);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; hv_override = ovr;
      @(posedge clk); #1;
      judge({tag, " bot"}, 1'b0, 1'b0, k, a, ovr, b_gv, b_gk, b_ga, b_kb, b_rj);
      judge({tag, " top"}, 1'b1, 1'b1, k, a, ovr, t_gv, t_gk, t_ga, t_kb, t_rj);
      if (k == 2'b11) lk = 1;
      @(negedge clk);
      req_valid = 1'b0; hv_override = 1'b0;
      @(posedge clk); #1;
      check({tag, " pulse end R10"}, {b_gv, b_rj, b_kb, t_gv, t_rj, t_kb}, 6'b0);
   endtask

   task automatic id_read(input string tag, input bit mode, input logic [AW-1:0] a,
                          input logic [7:0] eb, input logic [7:0] et);
      @(negedge clk);
      id_mode = mode; rd_addr = a;
      #1;
      check({tag, " bot id"}, b_id, eb);
      check({tag, " top id"}, t_id, et);
      id_mode = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R10 reset outputs", {b_gv, b_rj, b_kb, t_gv, t_rj, t_kb}, 6'b0);
      @(negedge clk);
      preset = 1'b0;
      rst_n  = 1'b1;
      id_read("R9 fresh", 1'b1, 17'h00002, 8'h00, 8'h00);
   endtask

   task automatic t_unlocked();
      issue("R2 prog boot", 2'b00, 17'h00000, 1'b0);
      issue("R2 serase top", 2'b01, 17'h1FFFF, 1'b0);
      issue("R5 chip free", 2'b10, 17'h00000, 1'b0);
   endtask

   task automatic t_lock();
      issue("R6 lock req", 2'b11, 17'h00555, 1'b0);
      id_read("R9 bot addr", 1'b1, 17'h00002, 8'h01, 8'h00);
      id_read("R9 top addr", 1'b1, 17'h1C002, 8'h00, 8'h01);
      id_read("R9 mode off", 1'b0, 17'h00002, 8'h00, 8'h00);
      id_read("R9 near miss", 1'b1, 17'h00003, 8'h00, 8'h00);
   endtask

   task automatic t_boundaries();
      issue("R1 R3 bot first", 2'b00, 17'h00000, 1'b0);
      issue("R1 R3 bot last", 2'b01, 17'h03FFF, 1'b0);
      issue("R1 R4 bot past", 2'b00, 17'h04000, 1'b0);
      issue("R1 R4 top below", 2'b01, 17'h1BFFF, 1'b0);
      issue("R1 R3 top first", 2'b00, 17'h1C000, 1'b0);
      issue("R4 middle", 2'b00, 17'h08000, 1'b0);
   endtask

   task automatic t_chip_locked();
      issue("R5 chip locked", 2'b10, 17'h00000, 1'b0);
   endtask

   task automatic t_override();
      issue("R7 R8 ovr bot", 2'b00, 17'h00100, 1'b1);
      issue("R7 R8 ovr top", 2'b00, 17'h1C100, 1'b1);
      issue("R7 R8 ovr chip", 2'b10, 17'h00000, 1'b1);
      issue("R7 ovr off", 2'b00, 17'h00100, 1'b0);
   endtask

   task automatic t_persist();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      id_read("R6 after rst", 1'b1, 17'h00002, 8'h01, 8'h00);
      issue("R6 still locked", 2'b01, 17'h00010, 1'b0);
      @(negedge clk);
      preset = 1'b1;
      @(negedge clk);
      preset = 1'b0;
      lk = 0;
      id_read("R6 preset", 1'b1, 17'h1C002, 8'h00, 8'h00);
      issue("R6 writable", 2'b00, 17'h00010, 1'b0);
      issue("R6 writable top", 2'b00, 17'h1C010, 1'b0);
   endtask

   initial begin
      t_reset();
      t_unlocked();
      t_lock();
      t_boundaries();
      t_chip_locked();
      t_override();
      t_persist();
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule